// File: doc/BRIEF.md
# Pipelined Sine/Cosine Rotation Engine

This block turns a signed phase word into its cosine and sine. It is a fully unrolled circular-rotation CORDIC pipeline. An input register folds the phase into the right half-plane and loads a start vector whose length already cancels the gain of the micro-rotations. A chain of stages follows, each turning the vector by a fixed elementary angle using shifts and adds only. A register sits after every stage, so the block takes a new phase on every clock and returns one result per clock once the pipeline is full.

The direction of each micro-rotation comes from the sign of the residual angle that travels with the vector. Phases beyond a quarter turn are moved by a half turn, and the start vector is negated in that case, so the whole circle is covered without an output multiplier or sign fix-up. A valid strobe runs beside the data and also serves as the clock enable of every stage register. Slots with no input therefore leave the outputs untouched.

Top module: `sincos_pipe`

## Requirements
- R1: While `rst_n` is low, and after its release until the first result, `out_valid` is 0 and `out_cos` and `out_sin` are 0.
- R2: A phase is taken on a rising edge where `in_valid` is 1. Its result appears with `out_valid` at 1 exactly STAGES+1 rising edges later (9 edges at the default of 8 stages), for one cycle per accepted phase.
- R3: The phase is a 16-bit two's-complement word in which 32768 counts a half turn (16384 = +90°, -16384 = -90°, -32768 = -180°). The outputs are signed Q1.14 (16384 = 1.0), with the cosine on `out_cos` and the sine on `out_sin`.
- R4: For phases from -16384 to +16384 inclusive, each output lies within 160 LSB of the exact cosine or sine scaled by 16384, and never exceeds 16384+160 in magnitude while `out_valid` is 1.
- R5: Phases beyond a quarter turn in either direction, including 32767 and -32768, give results within the same 160 LSB bound.
- R6: A new phase is accepted on every clock. Results leave in the order the phases were accepted, and any gaps in the input stream reappear as the same gaps at the output.
- R7: A cycle with `in_valid` at 0 produces no result, and the value on `in_angle` in that cycle has no effect. While `out_valid` is 0, `out_cos` and `out_sin` keep the last result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the clock |
| in_valid | input | 1 | Phase strobe |
| in_angle | input | 16 | Signed phase, a half turn per 32768 |
| out_valid | output | 1 | Result strobe |
| out_cos | output | 16 | Cosine, signed Q1.14 |
| out_sin | output | 16 | Sine, signed Q1.14 |

## Verification
Every result is due at the ninth rising edge after the edge that took its phase: one input register plus eight stage registers. The bench drives inputs on falling edges and stamps each issued phase with the count of rising edges seen so far. An output monitor, also running on falling edges, stamps each valid result in the same way, so a result counts as on time only if its stamp is exactly nine above the stamp of its phase. The single-phase test additionally watches `out_valid` cycle by cycle and expects it high only at offset nine. The gap and hold tests check that idle inputs produce idle output slots at the same offset, with the data held.

// File: rtl/sincos_pkg.sv
package sincos_pkg;

  // Precision of the reference tables: angles in 2^-23 half turns,
  // gain in 2^-24 units.
  localparam int TAB_W = 24;

  // 1/K for eight or more micro-rotations, scaled by 2^24.
  localparam int INV_GAIN_REF = 10188118;

  // arctan(2^-idx) in units of 2^-23 half turns.
  function automatic int atan_ref(input int idx);
    case (idx)
      0:  return 2097152;
      1:  return 1238021;
      2:  return 654136;
      3:  return 332050;
      4:  return 166669;
      5:  return 83416;
      6:  return 41718;
      7:  return 20860;
      8:  return 10430;
      9:  return 5215;
      10: return 2608;
      11: return 1304;
      12: return 652;
      13: return 326;
      14: return 163;
      15: return 81;
      default: return 0;
    endcase
  endfunction

  // Elementary angle rounded to an aw-bit phase word (aw < TAB_W).
  function automatic int atan_step(input int idx, input int aw);
    int tv;
    tv = atan_ref(idx);
    return (tv + (1 << (TAB_W - aw - 1))) >>> (TAB_W - aw);
  endfunction

  // Gain-compensated start length with frac fraction bits.
  function automatic int inv_gain(input int frac);
    return (INV_GAIN_REF + (1 << (TAB_W - frac - 1))) >>> (TAB_W - frac);
  endfunction

endpackage

// File: rtl/sincos_fold.sv
// Input register: half-plane folding and start-vector load.
module sincos_fold
  import sincos_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FRAC_W  = 14,
  parameter int ANGLE_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [ANGLE_W-1:0]        in_angle,
  output logic                      v_o,
  output logic signed [DATA_W-1:0]  x_o,
  output logic signed [DATA_W-1:0]  y_o,
  output logic signed [ANGLE_W-1:0] z_o
);

  localparam logic signed [ANGLE_W-1:0] QUARTER = ANGLE_W'(1) << (ANGLE_W - 2);
  localparam logic signed [DATA_W-1:0]  X_START = DATA_W'(inv_gain(FRAC_W));

  logic signed [ANGLE_W-1:0] a_in;
  logic                      wrap;
  logic signed [ANGLE_W-1:0] z_nx;
  logic signed [DATA_W-1:0]  x_nx;

  always_comb begin
    a_in = in_angle;
    wrap = (a_in > QUARTER) || (a_in < -QUARTER);
    // Adding a half turn only flips the sign bit of the phase word.
    z_nx = wrap ? {~a_in[ANGLE_W-1], a_in[ANGLE_W-2:0]} : a_in;
    x_nx = wrap ? -X_START : X_START;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o <= 1'b0;
    end else begin
      v_o <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0;
      z_o <= '0;
    end else if (in_valid) begin
      x_o <= x_nx;
      z_o <= z_nx;
    end
  end

  // The start vector always lies on the x axis.
  assign y_o = '0;

endmodule

// File: rtl/sincos_microrot.sv
// One shift-and-add micro-rotation of the (x, y) vector.
module sincos_microrot #(
  parameter int DATA_W = 16,
  parameter int SHIFT  = 0
) (
  input  logic signed [DATA_W-1:0] x_i,
  input  logic signed [DATA_W-1:0] y_i,
  input  logic                     ccw,
  output logic signed [DATA_W-1:0] x_o,
  output logic signed [DATA_W-1:0] y_o
);

  logic signed [DATA_W-1:0] x_sh;
  logic signed [DATA_W-1:0] y_sh;

  always_comb begin
    x_sh = x_i >>> SHIFT;
    y_sh = y_i >>> SHIFT;
    if (ccw) begin
      x_o = x_i - y_sh;
      y_o = y_i + x_sh;
    end else begin
      x_o = x_i + y_sh;
      y_o = y_i - x_sh;
    end
  end

endmodule

// File: rtl/sincos_pipe.sv
// Unrolled rotation-mode pipeline producing cosine and sine of a phase.
module sincos_pipe
  import sincos_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int FRAC_W  = 14,
  parameter int ANGLE_W = 16,
  parameter int STAGES  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [ANGLE_W-1:0]       in_angle,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_cos,
  output logic signed [DATA_W-1:0] out_sin
);

  localparam int LAST = STAGES - 1;

  logic [STAGES:0]               v_s;
  logic [STAGES:0][DATA_W-1:0]   x_s;
  logic [STAGES:0][DATA_W-1:0]   y_s;
  logic [STAGES-2:0][ANGLE_W-1:0] z_s;
  logic                          d_last;

  logic signed [DATA_W-1:0]  x0;
  logic signed [DATA_W-1:0]  y0;
  logic signed [ANGLE_W-1:0] z0;
  logic                      v0;

  sincos_fold #(
    .DATA_W (DATA_W),
    .FRAC_W (FRAC_W),
    .ANGLE_W(ANGLE_W)
  ) u_fold (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .in_angle(in_angle),
    .v_o     (v0),
    .x_o     (x0),
    .y_o     (y0),
    .z_o     (z0)
  );

  assign v_s[0] = v0;
  assign x_s[0] = x0;
  assign y_s[0] = y0;
  assign z_s[0] = z0;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic                     dir;
    logic signed [DATA_W-1:0] x_r;
    logic signed [DATA_W-1:0] y_r;
    logic                     v_q;
    logic signed [DATA_W-1:0] x_q;
    logic signed [DATA_W-1:0] y_q;

    // Turn toward the target: positive residual means counter-clockwise.
    if (i == LAST) begin : g_dir_last
      assign dir = d_last;
    end else begin : g_dir_res
      assign dir = ~z_s[i][ANGLE_W-1];
    end

    sincos_microrot #(
      .DATA_W(DATA_W),
      .SHIFT (i)
    ) u_rot (
      .x_i(x_s[i]),
      .y_i(y_s[i]),
      .ccw(dir),
      .x_o(x_r),
      .y_o(y_r)
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
      end else begin
        v_q <= v_s[i];
      end
    end

    // The valid bit of the slot is the clock enable of its data.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x_q <= '0;
        y_q <= '0;
      end else if (v_s[i]) begin
        x_q <= x_r;
        y_q <= y_r;
      end
    end

    assign v_s[i+1] = v_q;
    assign x_s[i+1] = x_q;
    assign y_s[i+1] = y_q;

    if (i < STAGES - 2) begin : g_res
      localparam logic signed [ANGLE_W-1:0] ALPHA = ANGLE_W'(atan_step(i, ANGLE_W));
      logic signed [ANGLE_W-1:0] z_cur;
      logic signed [ANGLE_W-1:0] z_nx;
      logic signed [ANGLE_W-1:0] z_q;

      always_comb begin
        z_cur = z_s[i];
        z_nx  = dir ? z_cur - ALPHA : z_cur + ALPHA;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          z_q <= '0;
        end else if (v_s[i]) begin
          z_q <= z_nx;
        end
      end

      assign z_s[i+1] = z_q;
    end else if (i == STAGES - 2) begin : g_sign
      // Only the sign of the final residual is needed downstream.
      localparam logic signed [ANGLE_W-1:0] ALPHA = ANGLE_W'(atan_step(i, ANGLE_W));
      logic signed [ANGLE_W-1:0] z_cur;
      logic                      d_nx;
      logic                      d_q;

      always_comb begin
        z_cur = z_s[i];
        d_nx  = dir ? (z_cur >= ALPHA) : (z_cur >= -ALPHA);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          d_q <= 1'b0;
        end else if (v_s[i]) begin
          d_q <= d_nx;
        end
      end

      assign d_last = d_q;
    end
  end

  assign out_valid = v_s[STAGES];
  assign out_cos   = x_s[STAGES];
  assign out_sin   = y_s[STAGES];

endmodule

// File: rtl/sincos_pipe_chk.sv
module sincos_pipe_chk #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 14,
  parameter int LAT    = 9
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic signed [DATA_W-1:0] out_cos,
  input logic signed [DATA_W-1:0] out_sin
);

  localparam int LIM = (1 << FRAC_W) + 160;
  localparam int CW  = $clog2(LAT + 1);

  logic [LAT-1:0] hist;
  logic [CW-1:0]  since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '0;
    end else begin
      hist <= {hist[LAT-2:0], in_valid};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != CW'(LAT)) begin
      since_rst <= since_rst + 1'b1;
    end
  end

  // R1
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < CW'(LAT)) |-> !out_valid);

  // R2
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == hist[LAT-1]);

  // R4
  output_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_cos <= LIM) && (out_cos >= -LIM) &&
                  (out_sin <= LIM) && (out_sin >= -LIM));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_cos) && $stable(out_sin)));

endmodule

bind sincos_pipe sincos_pipe_chk #(
  .DATA_W(DATA_W),
  .FRAC_W(FRAC_W),
  .LAT   (STAGES + 1)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_cos  (out_cos),
  .out_sin  (out_sin)
);

// File: tb/sincos_pipe_test.sv
module sincos_pipe_test;

  localparam int    LAT  = 9;
  localparam int    TOL  = 160;
  localparam int    NMAX = 1024;
  localparam real   PI   = 3.14159265358979;

  logic               clk;
  logic               rst_n;
  logic               in_valid;
  logic [15:0]        in_angle;
  logic               out_valid;
  logic signed [15:0] out_cos;
  logic signed [15:0] out_sin;

  int checks;
  int errors;
  int cyc;

  int          iss_n;
  int          iss_cyc [NMAX];
  logic [15:0] iss_ang [NMAX];
  int          log_n;
  int          log_cyc [NMAX];
  int          log_cos [NMAX];
  int          log_sin [NMAX];

  sincos_pipe uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_angle (in_angle),
    .out_valid(out_valid),
    .out_cos  (out_cos),
    .out_sin  (out_sin)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    if (rst_n && out_valid && log_n < NMAX) begin
      log_cyc[log_n] = cyc;
      log_cos[log_n] = int'(out_cos);
      log_sin[log_n] = int'(out_sin);
      log_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [15:0] a);
    in_valid = 1'b1;
    in_angle = a;
    iss_cyc[iss_n] = cyc;
    iss_ang[iss_n] = a;
    iss_n++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      in_valid = 1'b0;
      in_angle = 16'(cyc * 7919);
      @(negedge clk);
    end
  endtask

  // Compare every result logged since index first with the exact values.
  task automatic check_batch(input int first);
    for (int k = first; k < iss_n; k++) begin
      int  sa;
      real r;
      int  ec;
      int  es;
      string req;
      sa  = int'($signed(iss_ang[k]));
      r   = $itor(sa) * PI / 32768.0;
      ec  = int'($cos(r) * 16384.0);
      es  = int'($sin(r) * 16384.0);
      req = (sa > 16384 || sa < -16384) ? "R5" : "R4";
      if (k >= log_n) begin
        chk(1'b0, "R6", "missing result", log_n, k + 1);
      end else begin
        chk(log_cyc[k] == iss_cyc[k] + LAT, "R2", "result cycle",
            log_cyc[k], iss_cyc[k] + LAT);
        chk((log_cos[k] - ec <= TOL) && (ec - log_cos[k] <= TOL), req,
            $sformatf("cos of %0d", sa), log_cos[k], ec);
        chk((log_sin[k] - es <= TOL) && (es - log_sin[k] <= TOL), req,
            $sformatf("sin of %0d", sa), log_sin[k], es);
      end
    end
  endtask

  // R1: quiet outputs in and right after reset
  task automatic t_reset();
    for (int k = 0; k < 3; k++) begin
      chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
      chk(out_cos == 0 && out_sin == 0, "R1", "data in reset", out_cos, 0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk(out_valid == 1'b0, "R1", "valid after release", out_valid, 0);
      @(negedge clk);
    end
  endtask

  // R2: a single phase appears exactly at offset nine
  task automatic t_latency();
    int first;
    first = iss_n;
    issue(16'd0);
    for (int k = 1; k <= 12; k++) begin
      chk(out_valid == (k == LAT), "R2", $sformatf("valid at offset %0d", k),
          out_valid, (k == LAT));
      idle(1);
    end
    check_batch(first);
  endtask

  // R3, R4: phases inside the right half-plane
  task automatic t_inner();
    int first;
    first = iss_n;
    issue(16'd16384);
    issue(16'hC000);
    issue(16'd5461);
    issue(16'd2731);
    issue(16'hE000);
    for (int a = -16384; a <= 16384; a += 997) issue(16'(a));
    idle(LAT + 3);
    check_batch(first);
    // R3: +90 degrees is the first issued phase of this batch
    chk(log_sin[first] > 16000, "R3", "sin of quarter turn", log_sin[first], 16384);
    chk(log_sin[first + 1] < -16000, "R3", "sin of minus quarter turn",
        log_sin[first + 1], -16384);
  endtask

  // R5: phases that need folding
  task automatic t_outer();
    int first;
    first = iss_n;
    issue(16'd16385);
    issue(16'hBFFF);
    issue(16'd32767);
    issue(16'h8000);
    issue(16'd24576);
    issue(16'hA000);
    for (int a = 16500; a <= 32767; a += 1531) issue(16'(a));
    for (int a = -32768; a < -16384; a += 1409) issue(16'(a));
    idle(LAT + 3);
    check_batch(first);
    chk(log_cos[first + 3] < -16000, "R5", "cos of half turn", log_cos[first + 3], -16384);
  endtask

  // R6: gaps in the stream come out as the same gaps, in order
  task automatic t_stream();
    int first;
    first = iss_n;
    for (int k = 0; k < 24; k++) begin
      issue(16'(k * 2741 - 30000));
      if (k % 3 == 1) idle(1);
      if (k % 5 == 4) idle(2);
    end
    idle(LAT + 3);
    chk(log_n == iss_n, "R6", "result count", log_n, iss_n);
    check_batch(first);
  endtask

  // R7: idle slots leave the outputs alone whatever in_angle holds
  task automatic t_ignore();
    int hc;
    int hs;
    issue(16'd9000);
    idle(LAT + 2);
    hc = int'(out_cos);
    hs = int'(out_sin);
    for (int k = 0; k < 20; k++) begin
      idle(1);
      chk(out_valid == 1'b0, "R7", "valid while idle", out_valid, 0);
      chk(int'(out_cos) == hc && int'(out_sin) == hs, "R7", "held cosine",
          int'(out_cos), hc);
    end
    check_batch(iss_n - 1);
  endtask

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks   = 0;
    errors   = 0;
    cyc      = 0;
    iss_n    = 0;
    log_n    = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_angle = 16'h0;
    @(negedge clk);
    t_reset();
    t_latency();
    t_inner();
    t_outer();
    t_stream();
    t_ignore();
    chk(log_n == iss_n, "R6", "total results", log_n, iss_n);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule